// File: doc/BRIEF.md
# Fixed-Point Inverse Square Root Unit

This unit returns a coarse approximation of 1/sqrt(x) for a positive 16-bit fixed-point operand with five integer bits and eleven fraction bits (Q5.11). The result uses the same Q5.11 format. It is meant to sit beside a multiply-accumulate datapath in matrix factorisation work, where the diagonal divisions are turned into multiplications by a reciprocal square root. It has no multiplier and no stored table.

The operand is first normalised. A priority encoder counts the leading zeros, and a barrel shift turns the operand into a mantissa of the form 1.f. The exponent is alpha = leading zeros minus 4. Its parity selects one of two families of straight-line segments: one family fits 1/sqrt(m) over [1,2), and the other fits sqrt(2)/sqrt(m) over the same interval. The top LINE_BITS mantissa bits pick the segment. Each segment is evaluated as a start value minus at most three shifted copies of the in-segment offset. All segment constants are computed when the design is built. Finally, one of a bank of hardwired right shifts, chosen by k = floor(alpha/2), scales the line value. Results that are too large saturate.

A mode input selects between two ranges. In full-range mode any positive input is accepted. In subunitary mode only inputs up to 1.0 are accepted, and larger inputs are flagged. The operand and result are both registered, and the unit accepts one input per clock.

Top module: `isqrt_unit`

## Requirements
- R1: While rstN is low and after it is released, validOut, yOut, zeroErr and rangeErr are all 0 until the first result is registered.
- R2: For each cycle in which validIn is sampled high, validOut pulses high for one cycle, two rising edges later, together with that input's result. validOut never rises otherwise.
- R3: An input that is an exact even power of two of 1.0 gives the exact result 2^(-j) in Q5.11, provided it is representable. Such an input is x = 2^(2j), which is a single set bit at an odd bit position p with 2j = p - 11. Examples: 0x0800 gives 0x0800, and 0x0200 gives 0x1000.
- R4: For a nonzero accepted input with even alpha, yOut differs from 2048/sqrt(x/2048) by at most ideal/32 + 2 LSB.
- R5: For an input with odd alpha, such as 2.0 (0x1000) or 0.5 (0x0400), the same error bound holds, using the sqrt(2)-scaled line set.
- R6: In full-range mode (fullRange = 1), inputs of 2.0 and above, which give a negative alpha, are accepted without a flag and meet the R4 bound.
- R7: When the true result is 32.0 or more, yOut is 0xFFFF and no flag is raised. Examples: 0x0001 and 0x0002.
- R8: An input of 0 in either mode gives zeroErr = 1, rangeErr = 0 and yOut = 0xFFFF.
- R9: In subunitary mode (fullRange = 0), an input above 0x0800 gives rangeErr = 1, zeroErr = 0 and yOut = 0. An input of exactly 0x0800 is not flagged.
- R10: While validIn is low, yOut, zeroErr and rangeErr hold their values whatever xIn and fullRange do. The next accepted input overwrites both flags.
- R11: Inputs may be applied on every cycle, and the results come out in the order the inputs were applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operand on xIn is valid this cycle |
| xIn | input | 16 | Operand, unsigned Q5.11 |
| fullRange | input | 1 | 1 = any positive operand, 0 = operand limited to 1.0 |
| validOut | output | 1 | Result on yOut is new this cycle |
| yOut | output | 16 | Approximation of 1/sqrt(x), unsigned Q5.11 |
| zeroErr | output | 1 | Operand was zero |
| rangeErr | output | 1 | Operand exceeded 1.0 in subunitary mode |

## Verification
In any cycle of a continuous stream, the output register stores the result of one operand while the input register captures the next operand. A flagged operand can therefore leave the pipe in the same cycle that an ordinary operand enters it, and the flags must then change on the very next result. The stream provokes this by placing zero and over-range operands back to back with normal ones, in both modes, with no idle cycles. A scoreboard that records the due cycle and the mode of each operand judges every result.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
    logic forceMax;
    logic forceZero;
  } isqStrobe_t;

  // integer square root, bit by bit, for elaboration-time constants
  function automatic longint isqrtConst(longint v);
    longint res;
    longint tmp;
    res = 0;
    for (int b = 30; b >= 0; b--) begin
      tmp = res | (longint'(1) << b);
      if (tmp * tmp <= v) res = tmp;
    end
    return res;
  endfunction

  // value of the fitted curve at mantissa 1 + seg/2^nb, scaled by 2^cf
  function automatic longint lineEnd(int seg, int odd, int nb, int cf);
    return isqrtConst((longint'(1) << (2 * cf + odd + nb)) /
                      ((longint'(1) << nb) + longint'(seg)));
  endfunction

  // signed power of two nearest to d (0 for d == 0)
  function automatic longint nearestPow2(longint d);
    longint a;
    longint p;
    a = (d < 0) ? -d : d;
    if (a == 0) return 0;
    p = 1;
    while (p * 2 <= a) p = p * 2;
    if (a - p > 2 * p - a) p = p * 2;
    return (d < 0) ? -p : p;
  endfunction

  // pack a power-of-two term as {used, negative, exponent}
  function automatic int encodeTerm(longint p, int ew);
    longint a;
    int e;
    a = (p < 0) ? -p : p;
    if (a == 0) return 0;
    e = 0;
    while ((longint'(1) << e) < a) e++;
    return (1 << (ew + 1)) | (((p < 0) ? 1 : 0) << ew) | e;
  endfunction

endpackage

// File: rtl/isqrt_lines.sv
module isqrt_lines
  import isqrt_pkg::*;
#(
  parameter int LINE_BITS = 2,
  parameter int CORE_FRAC = 14,
  parameter int RB        = 13
) (
  input  logic [LINE_BITS:0]   lineIdx,
  input  logic [RB-1:0]        frac,
  output logic [CORE_FRAC+1:0] core
);

  localparam int SEGS  = 2 ** LINE_BITS;
  localparam int T     = 2 * SEGS;
  localparam int CW    = CORE_FRAC + 2;
  localparam int EXPW  = $clog2(CORE_FRAC + 2);
  localparam int TERMS = 3;
  localparam int PW    = RB + CW;
  localparam int AW    = CW + 2;

  logic [CW-1:0]   baseTab [T];
  logic [EXPW+1:0] termTab [T][TERMS];

  generate
    for (genvar t = 0; t < T; t++) begin : g_line
      localparam longint Y0 = lineEnd(t % SEGS, t / SEGS, LINE_BITS, CORE_FRAC);
      localparam longint Y1 = lineEnd(t % SEGS + 1, t / SEGS, LINE_BITS, CORE_FRAC);
      localparam longint D  = Y0 - Y1;
      localparam longint P0 = nearestPow2(D);
      localparam longint P1 = nearestPow2(D - P0);
      localparam longint P2 = nearestPow2(D - P0 - P1);
      assign baseTab[t]    = CW'(Y0);
      assign termTab[t][0] = (EXPW+2)'(encodeTerm(P0, EXPW));
      assign termTab[t][1] = (EXPW+2)'(encodeTerm(P1, EXPW));
      assign termTab[t][2] = (EXPW+2)'(encodeTerm(P2, EXPW));
    end
  endgenerate

  logic [AW-1:0]   acc;
  logic [AW-1:0]   part;
  logic [PW-1:0]   prod;
  logic [EXPW+1:0] sel;

  // start value minus up to three shifted copies of the in-segment offset
  always_comb begin
    acc  = AW'(baseTab[lineIdx]);
    part = '0;
    prod = '0;
    sel  = '0;
    for (int i = 0; i < TERMS; i++) begin
      sel  = termTab[lineIdx][i];
      prod = PW'(frac) << sel[EXPW-1:0];
      part = AW'(prod >> RB);
      if (sel[EXPW+1]) acc = sel[EXPW] ? (acc + part) : (acc - part);
    end
    core = acc[AW-1] ? '0 : acc[CW-1:0];
  end

endmodule

// File: rtl/isqrt_dp.sv
module isqrt_dp
  import isqrt_pkg::*;
#(
  parameter int W         = 16,
  parameter int FRAC      = 11,
  parameter int LINE_BITS = 2,
  parameter int CORE_FRAC = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  isqStrobe_t strobe,
  input  logic [W-1:0] xIn,
  output logic       isZero,
  output logic       overOne,
  output logic [W-1:0] yOut
);

  localparam int IWL   = W - FRAC;
  localparam int ZOFF  = IWL - 1;            // leading zeros of 1.0
  localparam int LZW   = $clog2(W + 1);
  localparam int AW    = LZW + 2;
  localparam int RB    = W - 1 - LINE_BITS;
  localparam int CW    = CORE_FRAC + 2;
  localparam int KMAX  = (W - 1 - ZOFF) / 2;
  localparam int KMIN  = -((ZOFF + 1) / 2);
  localparam int KSPAN = KMAX - KMIN + 1;
  localparam int EW    = CW + KMAX;
  localparam int GAP   = CORE_FRAC - FRAC;
  localparam int ONE   = 1 << FRAC;

  logic [W-1:0]         xReg;
  logic [W-1:0]         yReg;
  logic [W-1:0]         norm;
  logic [LZW-1:0]       lz;
  logic signed [AW-1:0] alphaS;
  logic signed [AW-1:0] kS;
  logic signed [AW-1:0] jS;
  logic [LINE_BITS:0]   lineIdx;
  logic [CW-1:0]        core;
  logic [EW-1:0]        ext;
  logic [EW-1:0]        scaled;
  logic [EW-1:0]        cand [KSPAN];
  logic                 sat;

  always_ff @(posedge clk) begin
    if (!rstN)               xReg <= '0;
    else if (strobe.loadIn)  xReg <= xIn;
  end

  // priority encoder: leading-zero count
  always_comb begin
    lz = LZW'(W);
    for (int i = 0; i < W; i++) begin
      if (xReg[i]) lz = LZW'(W - 1 - i);
    end
  end

  assign norm    = xReg << lz;
  assign alphaS  = $signed({2'b00, lz}) - $signed(AW'(ZOFF));
  assign kS      = alphaS >>> 1;
  assign jS      = $signed(AW'(KMAX)) - kS;
  assign lineIdx = {alphaS[0], norm[W-2 -: LINE_BITS]};

  isqrt_lines #(
    .LINE_BITS (LINE_BITS),
    .CORE_FRAC (CORE_FRAC),
    .RB        (RB)
  ) u_lines (
    .lineIdx (lineIdx),
    .frac    (norm[RB-1:0]),
    .core    (core)
  );

  assign ext = EW'(core) << KMAX;

  // hardwired shifts, one per exponent, picked by a mux
  generate
    for (genvar j = 0; j < KSPAN; j++) begin : g_shift
      assign cand[j] = ext >> (j + GAP);
    end
  endgenerate

  always_comb begin
    scaled = '0;
    for (int j = 0; j < KSPAN; j++) begin
      if (jS == $signed(AW'(j))) scaled = cand[j];
    end
  end

  assign sat     = |scaled[EW-1:W];
  assign isZero  = (xReg == '0);
  assign overOne = (xReg > W'(ONE));

  always_ff @(posedge clk) begin
    if (!rstN) yReg <= '0;
    else if (strobe.loadOut) begin
      if (strobe.forceMax)       yReg <= '1;
      else if (strobe.forceZero) yReg <= '0;
      else if (sat)              yReg <= '1;
      else                       yReg <= scaled[W-1:0];
    end
  end

  assign yOut = yReg;

  // normalisation must bring a one into the top bit
  assert_norm_lead_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xReg != '0) |-> norm[W-1]);

  // line value stays inside the span of both curves on [1,2)
  assert_core_span_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xReg != '0) |-> ((core >= CW'(1 << (CORE_FRAC - 1))) &&
                      (core <= CW'((3 << CORE_FRAC) / 2))));

endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
  import isqrt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic       fullRange,
  input  logic       isZero,
  input  logic       overOne,
  output isqStrobe_t strobe,
  output logic       validOut,
  output logic       zeroErr,
  output logic       rangeErr
);

  logic vIn;
  logic modeReg;
  logic vOut;
  logic zErr;
  logic rErr;
  logic outRange;

  assign outRange = vIn & ~isZero & ~modeReg & overOne;

  always_comb begin
    strobe.loadIn    = validIn;
    strobe.loadOut   = vIn;
    strobe.forceMax  = vIn & isZero;
    strobe.forceZero = outRange;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vIn     <= 1'b0;
      modeReg <= 1'b0;
      vOut    <= 1'b0;
      zErr    <= 1'b0;
      rErr    <= 1'b0;
    end else begin
      vIn  <= validIn;
      vOut <= vIn;
      if (validIn) modeReg <= fullRange;
      if (vIn) begin
        zErr <= isZero;
        rErr <= outRange;
      end
    end
  end

  assign validOut = vOut;
  assign zeroErr  = zErr;
  assign rangeErr = rErr;

  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(zeroErr && rangeErr));

  assert_range_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rangeErr) |-> !$past(modeReg));

endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit
  import isqrt_pkg::*;
#(
  parameter int W         = 16,
  parameter int FRAC      = 11,
  parameter int LINE_BITS = 2,
  parameter int CORE_FRAC = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic [W-1:0] xIn,
  input  logic         fullRange,
  output logic         validOut,
  output logic [W-1:0] yOut,
  output logic         zeroErr,
  output logic         rangeErr
);

  isqStrobe_t strobe;
  logic       isZero;
  logic       overOne;

  isqrt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .fullRange (fullRange),
    .isZero    (isZero),
    .overOne   (overOne),
    .strobe    (strobe),
    .validOut  (validOut),
    .zeroErr   (zeroErr),
    .rangeErr  (rangeErr)
  );

  isqrt_dp #(
    .W         (W),
    .FRAC      (FRAC),
    .LINE_BITS (LINE_BITS),
    .CORE_FRAC (CORE_FRAC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .xIn     (xIn),
    .isZero  (isZero),
    .overOne (overOne),
    .yOut    (yOut)
  );

  assert_zero_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && zeroErr) |-> (yOut == '1));

  assert_range_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && rangeErr) |-> (yOut == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |=> ($stable(yOut) && $stable(zeroErr) && $stable(rangeErr)));

  assert_pulse_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> $past(validIn, 2));

endmodule

// File: tb/isqrt_unit_test.sv
module isqrt_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [15:0] xIn = 16'h0;
  logic        fullRange = 1'b1;
  logic        validOut;
  logic [15:0] yOut;
  logic        zeroErr;
  logic        rangeErr;

  isqrt_unit uut (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .xIn       (xIn),
    .fullRange (fullRange),
    .validOut  (validOut),
    .yOut      (yOut),
    .zeroErr   (zeroErr),
    .rangeErr  (rangeErr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    x;
    bit    mode;
    int    due;
    string tag;
  } item_t;

  item_t pend[$];
  int checks = 0;
  int fails = 0;
  int sent = 0;
  int seen = 0;
  bit done = 1'b0;

  function automatic bit isPow4(int x);
    int p;
    if ($countones(x) != 1) return 1'b0;
    p = $clog2(x);
    return (p % 2) == 1;
  endfunction

  task automatic judge(item_t it);
    real   ideal;
    int    expY;
    int    tol;
    int    diff;
    bit    expZ;
    bit    expR;
    string req;
    tol  = 0;
    expZ = 1'b0;
    expR = 1'b0;
    if (it.x == 0) begin
      expY = 65535; expZ = 1'b1; req = "R8";
    end else if (!it.mode && it.x > 2048) begin
      expY = 0; expR = 1'b1; req = "R9";
    end else begin
      ideal = 2048.0 / $sqrt(it.x / 2048.0);
      if (ideal >= 65536.0) begin
        expY = 65535; req = "R7";
      end else if (isPow4(it.x)) begin
        expY = int'(ideal); req = "R3";
      end else begin
        expY = int'(ideal); tol = int'(ideal / 32.0) + 2; req = it.tag;
        if (expY > 65535) expY = 65535;
      end
    end
    checks++;
    diff = int'(yOut) - expY;
    if (diff < 0) diff = -diff;
    if (cyc != it.due) begin
      fails++;
      $display("FAIL R2 x=%h result at cycle %0d expected cycle %0d", it.x, cyc, it.due);
    end else if (diff > tol || zeroErr != expZ || rangeErr != expR) begin
      fails++;
      $display("FAIL %s x=%h mode=%0d got y=%h z=%0d r=%0d expected y=%h(+-%0d) z=%0d r=%0d",
               req, it.x, it.mode, yOut, zeroErr, rangeErr, expY[15:0], tol, expZ, expR);
    end
  endtask

  // monitor: pop and compare each result
  always @(negedge clk) begin
    item_t it;
    if (rstN && validOut) begin
      seen++;
      if (pend.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 validOut with nothing pending, got y=%h expected no result", yOut);
      end else begin
        it = pend.pop_front();
        judge(it);
      end
    end
  end

  task automatic send(int x, bit mode);
    item_t it;
    int    p;
    @(negedge clk);
    validIn   = 1'b1;
    xIn       = x[15:0];
    fullRange = mode;
    p = (x > 0) ? $clog2(x + 1) - 1 : 0;
    it.x    = x;
    it.mode = mode;
    it.due  = cyc + 2;
    it.tag  = (x >= 4096) ? "R6" : (((p % 2) == 0) ? "R5" : "R4");
    pend.push_back(it);
    sent++;
  endtask

  task automatic idle(int n, int xNoise, bit modeNoise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn   = 1'b0;
      xIn       = xNoise[15:0];
      fullRange = modeNoise;
    end
  endtask

  task automatic checkHold(int expY, bit expZ, bit expR);
    checks++;
    if (validOut || yOut != expY[15:0] || zeroErr != expZ || rangeErr != expR) begin
      fails++;
      $display("FAIL R10 idle: got v=%0d y=%h z=%0d r=%0d expected v=0 y=%h z=%0d r=%0d",
               validOut, yOut, zeroErr, rangeErr, expY[15:0], expZ, expR);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired, got pending=%0d expected 0", pend.size());
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (validOut || yOut != 16'h0 || zeroErr || rangeErr) begin
      fails++;
      $display("FAIL R1 reset: got v=%0d y=%h z=%0d r=%0d expected all 0",
               validOut, yOut, zeroErr, rangeErr);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (validOut || yOut != 16'h0) begin
      fails++;
      $display("FAIL R1 after release: got v=%0d y=%h expected 0 0", validOut, yOut);
    end

    // R3 exact powers of four and other single-bit inputs, both modes
    for (int p = 0; p < 16; p++) send(1 << p, 1'b1);
    for (int p = 0; p < 16; p++) send(1 << p, 1'b0);

    // corners: R7 saturation, R8 zero, R9 boundary, R5 odd exponent
    send(0, 1'b1);
    send(16'h0800, 1'b0);
    send(16'h0801, 1'b0);
    send(0, 1'b0);
    send(16'h0003, 1'b1);
    send(16'h1000, 1'b1);
    send(16'h0400, 1'b0);
    send(16'hFFFF, 1'b1);
    send(16'hFFFF, 1'b0);
    send(16'h0001, 1'b1);
    send(16'h0002, 1'b0);
    idle(4, 16'h0, 1'b1);

    // R10: hold while idle, with noise on the inputs
    send(16'h0800, 1'b1);
    idle(6, 0, 1'b0);
    checkHold(2048, 1'b0, 1'b0);
    send(0, 1'b1);
    idle(6, 16'h0800, 1'b1);
    checkHold(65535, 1'b1, 1'b0);
    send(16'h2000, 1'b0);
    idle(6, 0, 1'b1);
    checkHold(0, 1'b0, 1'b1);
    send(16'h2000, 1'b1);
    idle(4, 0, 1'b0);
    checkHold(1024, 1'b0, 1'b0);

    // R11 / R4 / R5 / R6: unbroken streams in both modes
    for (int x = 1; x < 65536; x += 41) send(x, 1'b1);
    for (int x = 0; x < 4200; x += 13) send(x, 1'b0);
    for (int x = 0; x < 64; x++) send((x * 997 + 5) % 65536, x[0]);
    idle(5, 0, 1'b1);

    // R11: every input produced exactly one result, in order
    checks++;
    if (pend.size() != 0 || seen != sent) begin
      fails++;
      $display("FAIL R11 results: got %0d seen, %0d pending expected %0d seen, 0 pending",
               seen, pend.size(), sent);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule